// File: doc/BRIEF.md
# UART Request and Interrupt-Enable Unit

This block sits beside the receive and transmit datapaths of a 16550-style UART. It holds the interrupt-enable state and drives three separate request lines: one for received data, one for an empty transmit holding register, and one for line errors. Each line depends only on its own enable bit and the line-status flags that feed it. The line-status flags come in live from the serial datapath. The receive and transmit lines can also serve directly as DMA request strobes, so setting their enable bits is what starts DMA traffic.

A small register port reaches four offsets. Offset 0 is shared between the enable register and the divisor high byte, and bit 7 of the line control byte picks which of the two is seen. Offset 1 is a read-only identification code for software that expects a single prioritised interrupt source. Offset 2 is the line control byte. Offset 3 reads as zero. The divisor high byte and the line control byte are driven out to the rest of the UART.

Top module: `uart_irq_unit`

## Requirements
- R1: After reset, the enable register, the divisor high byte and the line control byte are all 0, all three request outputs are low, and offset 1 reads 0x0001.
- R2: rx_req is high exactly when enable bit 0 is 1 and line_stat bit 0 (data ready) is 1.
- R3: tx_req is high exactly when enable bit 1 is 1 and line_stat bit 5 (transmit holding empty) is 1.
- R4: ls_req is high exactly when enable bit 2 is 1 and at least one of line_stat bits 4:1 is 1. Those bits are overrun (bit 1), parity (bit 2), framing (bit 3) and break (bit 4).
- R5: Each request line depends only on its own enable bit and its own status bits. Flags and enables that belong to the other lines have no effect on it.
- R6: At offset 0, when line_ctrl bit 7 is 0, reads and writes reach the enable register. When bit 7 is 1, they reach the divisor high byte (read as data bits 7:0, upper bits 0), and the enable register is left unchanged.
- R7: Enable bits 15:3 are reserved. Writes to them are ignored and they read back as 0.
- R8: Offset 1 reads 0x0006 when the line-status source is pending. Otherwise it reads 0x0004 when the receive source is pending. Otherwise it reads 0x0002 when the transmit source is pending.
- R9: A source counts as pending in offset 1 only if its enable bit is set. With nothing pending, offset 1 reads 0x0001.
- R10: A write takes effect at the rising clock edge where wr_en is sampled high. Request outputs and read data follow line_stat, addr and the stored state in the same cycle, with no register stage.
- R11: Offset 2 stores an 8-bit line control byte. It reads back in data bits 7:0 with the upper bits 0, and it is driven on line_ctrl.
- R12: Offset 1 is read-only. A write there changes no stored state.
- R13: Offset 3 reads as 0, and a write to it changes no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register offset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr, combinational |
| line_stat | input | 6 | Live line-status flags (bit 0 data ready, bits 4:1 errors, bit 5 transmit empty) |
| rx_req | output | 1 | Receive interrupt / DMA request |
| tx_req | output | 1 | Transmit interrupt / DMA request |
| ls_req | output | 1 | Line-status interrupt request |
| divisor_hi | output | 8 | Stored divisor high byte |
| line_ctrl | output | 8 | Stored line control byte |

## Verification
The request lines and the read data are combinational, so they are due in the same cycle as any change to line_stat or addr. The bench drives those inputs just after a falling edge and samples 2 ns later, well before the next rising edge. A register write is due one rising edge after wr_en is raised. One probe is taken while wr_en is still high, before that edge, to confirm the old value is still visible. The following probes are taken after the edge. The driver computes each expected item from its own model of the requirements when the probe is issued, and the monitor compares it in that same sampling window.

// File: rtl/uart_irq_unit.sv
module uart_irq_unit #(
  parameter int DW  = 16,
  parameter int AW  = 2,
  parameter int ENW = 3,
  parameter int BW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [5:0]    line_stat,
  output logic          rx_req,
  output logic          tx_req,
  output logic          ls_req,
  output logic [BW-1:0] divisor_hi,
  output logic [BW-1:0] line_ctrl
);
  localparam logic [AW-1:0] OFF_SHARED = AW'(0);
  localparam logic [AW-1:0] OFF_ID     = AW'(1);
  localparam logic [AW-1:0] OFF_LCTL   = AW'(2);
  localparam int            SEL_BIT    = BW - 1;
  localparam logic [3:0]    ID_NONE    = 4'h1;
  localparam logic [3:0]    ID_TX      = 4'h2;
  localparam logic [3:0]    ID_RX      = 4'h4;
  localparam logic [3:0]    ID_LS      = 4'h6;

  logic [ENW-1:0] en_q;
  logic [BW-1:0]  dlh_q, lcr_q;
  logic           sel_div;
  logic [3:0]     id_code;

  assign sel_div = lcr_q[SEL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      dlh_q <= '0;
      lcr_q <= '0;
    end else if (wr_en) begin
      if (addr == OFF_SHARED && !sel_div) en_q  <= wdata[ENW-1:0];
      if (addr == OFF_SHARED &&  sel_div) dlh_q <= wdata[BW-1:0];
      if (addr == OFF_LCTL)               lcr_q <= wdata[BW-1:0];
    end
  end

  assign rx_req = en_q[0] & line_stat[0];
  assign tx_req = en_q[1] & line_stat[5];
  assign ls_req = en_q[2] & (|line_stat[4:1]);

  always_comb begin
    if      (ls_req) id_code = ID_LS;
    else if (rx_req) id_code = ID_RX;
    else if (tx_req) id_code = ID_TX;
    else             id_code = ID_NONE;
  end

  always_comb begin
    case (addr)
      OFF_SHARED: rdata = sel_div ? DW'(dlh_q) : DW'(en_q);
      OFF_ID:     rdata = DW'(id_code);
      OFF_LCTL:   rdata = DW'(lcr_q);
      default:    rdata = '0;
    endcase
  end

  assign divisor_hi = dlh_q;
  assign line_ctrl  = lcr_q;
endmodule

module uart_irq_unit_chk #(
  parameter int DW = 16,
  parameter int AW = 2,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [5:0]    line_stat,
  input logic          rx_req,
  input logic          tx_req,
  input logic          ls_req,
  input logic [BW-1:0] divisor_hi,
  input logic [BW-1:0] line_ctrl
);
  p_rx_needs_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |-> line_stat[0]);
  p_tx_needs_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> line_stat[5]);
  p_ls_needs_error_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ls_req |-> (|line_stat[4:1]));
  p_div_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(0) && line_ctrl[BW-1]) |=> divisor_hi == $past(wdata[BW-1:0]));
  p_div_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(0) && line_ctrl[BW-1]) |-> rdata == DW'(divisor_hi));
  p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(0) && !line_ctrl[BW-1]) |-> rdata[DW-1:3] == '0);
  p_id_ls_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_req && addr == AW'(1)) |-> rdata == DW'(6));
  p_id_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_req && !tx_req && !ls_req && addr == AW'(1)) |-> rdata == DW'(1));
  p_lctl_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(2)) |=> line_ctrl == $past(wdata[BW-1:0]));
  p_id_write_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(1)) |=> ($stable(line_ctrl) && $stable(divisor_hi)));
  p_hole_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(3)) |-> rdata == '0);
endmodule

bind uart_irq_unit uart_irq_unit_chk #(.DW(DW), .AW(AW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .line_stat(line_stat), .rx_req(rx_req), .tx_req(tx_req),
  .ls_req(ls_req), .divisor_hi(divisor_hi), .line_ctrl(line_ctrl)
);

// File: tb/uart_irq_unit_tb.sv
module uart_irq_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [5:0]  line_stat = '0;
  logic        rx_req, tx_req, ls_req;
  logic [7:0]  divisor_hi, line_ctrl;

  always #10 clk = ~clk;

  uart_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .line_stat(line_stat), .rx_req(rx_req), .tx_req(tx_req),
    .ls_req(ls_req), .divisor_hi(divisor_hi), .line_ctrl(line_ctrl)
  );

  typedef struct {
    logic [15:0] rd;
    logic [2:0]  req;
    logic [7:0]  dlh;
    logic [7:0]  lcr;
    string       tag;
  } item_t;

  item_t q[$];
  event  ev_sample;
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  logic [2:0] m_en  = '0;
  logic [7:0] m_dlh = '0;
  logic [7:0] m_lcr = '0;

  function automatic logic [15:0] exp_read(input logic [1:0] a, input logic [5:0] ls);
    logic rx, tx, st;
    rx = m_en[0] & ls[0];
    tx = m_en[1] & ls[5];
    st = m_en[2] & (|ls[4:1]);
    case (a)
      2'd0: return m_lcr[7] ? {8'h00, m_dlh} : {13'h0, m_en};
      2'd1: return st ? 16'h6 : rx ? 16'h4 : tx ? 16'h2 : 16'h1;
      2'd2: return {8'h00, m_lcr};
      default: return 16'h0;
    endcase
  endfunction

  task automatic probe(input logic [1:0] a, input logic [5:0] ls, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    line_stat = ls;
    it.rd  = exp_read(a, ls);
    it.req = {m_en[2] & (|ls[4:1]), m_en[1] & ls[5], m_en[0] & ls[0]};
    it.dlh = m_dlh;
    it.lcr = m_lcr;
    it.tag = tag;
    #2;
    q.push_back(it);
    -> ev_sample;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 2'd0 && !m_lcr[7]) m_en = d[2:0];
    if (a == 2'd0 &&  m_lcr[7]) m_dlh = d[7:0];
    if (a == 2'd2) m_lcr = d[7:0];
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(ev_sample);
      it = q.pop_front();
      checks++;
      if (rdata !== it.rd || {ls_req, tx_req, rx_req} !== it.req ||
          divisor_hi !== it.dlh || line_ctrl !== it.lcr) begin
        failures++;
        $display("FAIL %s: rdata=%h req=%b dlh=%h lcr=%h expected rdata=%h req=%b dlh=%h lcr=%h",
                 it.tag, rdata, {ls_req, tx_req, rx_req}, divisor_hi, line_ctrl,
                 it.rd, it.req, it.dlh, it.lcr);
      end
    end
  end

  initial begin : watchdog
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    probe(2'd0, 6'h3F, "R1 enable reset");
    probe(2'd1, 6'h3F, "R1 id reset");
    probe(2'd2, 6'h00, "R1 lctl reset");
    reg_write(2'd0, 16'hFFFF);
    probe(2'd0, 6'h00, "R7 reserved read zero");
    probe(2'd1, 6'h00, "R9 none pending");
    probe(2'd1, 6'h01, "R2 rx from ready");
    probe(2'd1, 6'h20, "R3 tx from empty");
    for (int b = 1; b <= 4; b++) probe(2'd1, 6'(1 << b), "R4 each error bit");
    probe(2'd1, 6'h3F, "R8 status beats all");
    probe(2'd1, 6'h21, "R8 rx beats tx");
    reg_write(2'd0, 16'h0002);
    probe(2'd1, 6'h3F, "R5 tx only enabled");
    probe(2'd1, 6'h1F, "R9 disabled rx/status hidden");
    reg_write(2'd0, 16'h0004);
    probe(2'd1, 6'h21, "R5 status line ignores rx/tx");
    reg_write(2'd0, 16'h0001);
    probe(2'd0, 6'h1E, "R5 rx ignores errors");
    // R10: value unchanged while wr_en high before the edge
    @(negedge clk);
    addr = 2'd0; wdata = 16'h0006; wr_en = 1'b1;
    begin
      item_t it;
      it.rd = 16'h0001; it.req = 3'b001; it.dlh = m_dlh; it.lcr = m_lcr;
      it.tag = "R10 write not before edge";
      line_stat = 6'h01;
      #2; q.push_back(it); -> ev_sample;
    end
    @(negedge clk);
    wr_en = 1'b0;
    m_en = 3'b110;
    probe(2'd0, 6'h01, "R10 write after edge");
    reg_write(2'd2, 16'h0080);
    probe(2'd2, 6'h00, "R11 lctl readback");
    probe(2'd0, 6'h00, "R6 divisor view");
    reg_write(2'd0, 16'hABCD);
    probe(2'd0, 6'h3F, "R6 divisor write, enables kept");
    reg_write(2'd2, 16'hFF03);
    probe(2'd2, 6'h00, "R11 upper bits dropped");
    probe(2'd0, 6'h00, "R6 enable view restored");
    reg_write(2'd1, 16'h1234);
    probe(2'd0, 6'h20, "R12 id write ignored enables");
    probe(2'd2, 6'h00, "R12 id write ignored lctl");
    reg_write(2'd3, 16'hFFFF);
    probe(2'd3, 6'h3F, "R13 hole reads zero");
    probe(2'd0, 6'h00, "R13 hole write ignored");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule